// File: doc/BRIEF.md
# Ack-Ignoring Two-Wire Pin Latch Controller

This block is the host side of a link to a small remote output latch with five pins. The link is a two-wire I2C bus. The block holds three things per pin: a shadow copy of the remote latch bit, a saved output value, and a direction flag. A one-cycle command (set, toggle, get or direction change) updates these registers. When the command needs the bus, the block sequences a complete write or read frame on the two open-drain lines. Each line is pulled low by turning its driver on and is high only when released. Every line change is followed by a fixed wait of `STEP_CLKS` system clocks.

The remote target is known not to acknowledge its bytes. The controller therefore releases SDA for the acknowledge clock and then carries on without looking at the line, so the data byte is always written. A pin configured as input keeps its latch bit at 1, which puts the remote output into high impedance. Set and toggle commands on such a pin only change the saved value. That saved value is applied when the pin returns to output.

Top module: `pinlatch_i2c_ctrl`

## Requirements
- R1: After reset every pin is an output, and the shadow latch and saved values are all 0. Both line drivers are off and `busy` is low. No frame starts until a command needs one.
- R2: A write frame is sent MSB first and consists of:
  - a START (SDA falls while SCL is high);
  - the address byte 0xAC;
  - one acknowledge clock;
  - the data byte, with pin i of the shadow latch at bit i and the upper bits 0;
  - a second acknowledge clock;
  - the closing sequence, in which SCL rises, then SDA is released, then SCL falls, then SDA is pulled low.
- R3: During each acknowledge clock SDA is released, and whatever the line carries there is discarded. A target that leaves SDA high still receives the data byte, and the frame still completes.
- R4: A get on an input pin runs a read frame, which consists of:
  - a START;
  - the address byte 0xAD;
  - one acknowledge clock;
  - eight SCL pulses with SDA released, each sampled while SCL is high, MSB first;
  - the closing sequence, with no acknowledge driven by the master.

  The response data is bit `cmd_pin` of the received byte.
- R5: A command whose pin index is 5 or more returns `rsp_err`=1 in the cycle after acceptance and causes no bus activity.
- R6: A set (opcode 0) on an output pin copies `cmd_arg` into both the saved value and the latch bit, and then sends a write frame.
- R7: A set or toggle on an input pin changes only the saved value. It sends no frame and responds in the cycle after acceptance.
- R8: A direction command (opcode 3) with `cmd_arg`=1 makes the pin an input and forces its latch bit to 1. With `cmd_arg`=0 it makes the pin an output and loads its latch bit from the saved value. Either way a write frame follows.
- R9: A get (opcode 2) on an output pin returns the shadow latch bit in the cycle after acceptance, with no bus traffic.
- R10: `busy` is high from the cycle after a frame-starting command until the frame ends. While it is high, commands are ignored and `rsp_valid` stays low. `rsp_valid` pulses, with `rsp_err`=0, in the cycle `busy` falls.
- R11: A toggle (opcode 1) on an output pin inverts both the saved value and the latch bit, and then sends a write frame.
- R12: Within a frame, successive changes of the line drivers are at least `STEP_CLKS` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered this cycle; taken when `busy` is low |
| cmd_op | input | 2 | 0 set, 1 toggle, 2 get, 3 direction |
| cmd_pin | input | PIN_W | Pin index |
| cmd_arg | input | 1 | Value for set; for direction, 1 = input and 0 = output |
| busy | output | 1 | A bus frame is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | The pin index was out of range |
| rsp_data | output | 1 | Bit returned by a get |
| scl_lo | output | 1 | Turns on the SCL pull-down |
| sda_lo | output | 1 | Turns on the SDA pull-down |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The bench builds the block with `STEP_CLKS` = 4 and the default of five pins. This keeps each frame to a few hundred cycles, so one run can cover many write and read frames. It also lets the bench measure the minimum spacing between line changes exactly, and decode every SCL rising edge with a bus model. That model never acknowledges, and during read frames it returns a programmed byte. With five pins, indices 5 and 7 exercise the rejection path while the low pins cycle through the output and input states.

// File: rtl/pinlatch_i2c_ctrl.sv
module pinlatch_i2c_ctrl #(
  parameter int NPINS     = 5,
  parameter int PIN_W     = 3,
  parameter int STEP_CLKS = 2500,
  parameter logic [7:0] ADDR_BYTE = 8'hAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [PIN_W-1:0] cmd_pin,
  input  logic             cmd_arg,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             rsp_data,
  output logic             scl_lo,
  output logic             sda_lo,
  input  logic             sda_in
);
  localparam int TW = $clog2(STEP_CLKS + 1);
  localparam logic [1:0] OP_SET = 2'd0, OP_TOG = 2'd1, OP_GET = 2'd2, OP_DIR = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RX, S_STOP, S_DONE} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [1:0]       sub;
  logic [3:0]       bitn;
  logic             byten, rd;
  logic [7:0]       tx, rx;
  logic [PIN_W-1:0] op_pin;
  logic [NPINS-1:0] latch, saved, dir_in;

  wire take = cmd_valid && !busy;
  wire bad  = cmd_pin >= PIN_W'(NPINS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; sub <= '0; bitn <= '0; byten <= 1'b0; rd <= 1'b0;
      tx <= '0; rx <= '0; op_pin <= '0;
      latch <= '0; saved <= '0; dir_in <= '0;
      busy <= 1'b0; rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_data <= 1'b0;
      scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (take) begin
        rsp_err  <= 1'b0;
        rsp_data <= 1'b0;
        op_pin   <= cmd_pin;
        if (bad) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
        end else begin
          rd <= 1'b0;
          case (cmd_op)
            OP_SET: begin
              saved[cmd_pin] <= cmd_arg;
              if (!dir_in[cmd_pin]) latch[cmd_pin] <= cmd_arg;
            end
            OP_TOG: begin
              saved[cmd_pin] <= ~saved[cmd_pin];
              if (!dir_in[cmd_pin]) latch[cmd_pin] <= ~latch[cmd_pin];
            end
            OP_GET: begin
              rd <= dir_in[cmd_pin];
              if (!dir_in[cmd_pin]) rsp_data <= latch[cmd_pin];
            end
            default: begin
              dir_in[cmd_pin] <= cmd_arg;
              latch[cmd_pin]  <= cmd_arg | saved[cmd_pin];
            end
          endcase
          if (cmd_op == OP_DIR || !dir_in[cmd_pin] && cmd_op != OP_GET ||
              dir_in[cmd_pin] && cmd_op == OP_GET) begin
            busy  <= 1'b1;
            st    <= S_START;
            sub   <= '0;
            tmr   <= '0;
            bitn  <= '0;
            byten <= 1'b0;
            tx    <= ADDR_BYTE | {7'd0, cmd_op == OP_GET};
          end else begin
            rsp_valid <= 1'b1;
          end
        end
      end else if (busy && tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else if (busy) begin
        tmr <= TW'(STEP_CLKS - 1);
        sub <= sub + 1'b1;
        case (st)
          S_START: begin
            case (sub)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b1;
              default: begin scl_lo <= 1'b1; st <= S_TX; sub <= '0; end
            endcase
          end
          S_TX: begin
            if (bitn < 4'd8) begin
              case (sub)
                2'd0: sda_lo <= ~tx[7];
                2'd1: scl_lo <= 1'b0;
                default: begin
                  scl_lo <= 1'b1; tx <= {tx[6:0], 1'b0}; bitn <= bitn + 1'b1; sub <= '0;
                end
              endcase
            end else if (sub == 2'd0) begin
              scl_lo <= 1'b0;
              sda_lo <= 1'b0;
            end else begin
              scl_lo <= 1'b1;
              sub    <= '0;
              bitn   <= '0;
              if (rd)          st <= S_RX;
              else if (!byten) begin byten <= 1'b1; tx <= 8'(latch); end
              else             st <= S_STOP;
            end
          end
          S_RX: begin
            if (sub == 2'd0) begin
              scl_lo <= 1'b0;
            end else begin
              rx     <= {rx[6:0], sda_in};
              scl_lo <= 1'b1;
              bitn   <= bitn + 1'b1;
              sub    <= '0;
              if (bitn == 4'd7) st <= S_STOP;
            end
          end
          S_STOP: begin
            case (sub)
              2'd0: scl_lo <= 1'b0;
              2'd1: sda_lo <= 1'b0;
              2'd2: scl_lo <= 1'b1;
              default: begin sda_lo <= 1'b1; st <= S_DONE; end
            endcase
          end
          default: begin
            tmr       <= '0;
            st        <= S_IDLE;
            busy      <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_data  <= rd & rx[op_pin];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pinlatch_i2c_ctrl_chk.sv
module pinlatch_i2c_ctrl_chk #(
  parameter int NPINS = 5,
  parameter int PIN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [PIN_W-1:0] cmd_pin,
  input logic             busy,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             scl_lo,
  input logic             sda_lo,
  input logic [NPINS-1:0] dir_in
);
  wire take_ok = cmd_valid && !busy && (cmd_pin < PIN_W'(NPINS));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(scl_lo) && $stable(sda_lo)));

  // R10
  done_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rsp_valid && !rsp_err));

  // R10
  busy_quiet_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rsp_valid);

  // R5
  bad_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_pin >= PIN_W'(NPINS))) |=> (rsp_valid && rsp_err && !busy));

  // R7
  input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ok && cmd_op[1] == 1'b0 && dir_in[cmd_pin]) |=> (rsp_valid && !busy));

  // R9
  get_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ok && cmd_op == 2'd2 && !dir_in[cmd_pin]) |=> (rsp_valid && !busy));

  // R8
  dir_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ok && cmd_op == 2'd3) |=> busy);
endmodule

bind pinlatch_i2c_ctrl pinlatch_i2c_ctrl_chk #(.NPINS(NPINS), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pin(cmd_pin),
  .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .scl_lo(scl_lo), .sda_lo(sda_lo), .dir_in(dir_in)
);

// File: tb/test_pinlatch_i2c_ctrl.sv
`timescale 1ns/1ps
module test_pinlatch_i2c_ctrl;
  localparam int STEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_arg = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [2:0] cmd_pin = '0;
  logic busy, rsp_valid, rsp_err, rsp_data, scl_lo, sda_lo;
  logic scl_line, sda_line, tgt_lo;

  int checks = 0, errors = 0;
  int nstart = 0, rcnt = 0, fcnt = 0, rsp_cnt = 0;
  int cyc = 0, last_chg = 0, mingap = 1000000;
  bit have_last = 0, done = 0, rdf = 0;
  logic [31:0] bits = '0;
  logic [7:0] tgt_byte = 8'h00;
  logic [1:0] prev_lines = 2'b00;
  logic r_err, r_data;
  int   r_lat;

  always #2 clk = ~clk;

  assign scl_line = !scl_lo;
  assign tgt_lo   = rdf && (fcnt >= 10) && (fcnt <= 17) && !tgt_byte[17 - fcnt];
  assign sda_line = !sda_lo && !tgt_lo;

  pinlatch_i2c_ctrl #(.STEP_CLKS(STEP)) i_pinlatch_i2c_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pin(cmd_pin),
    .cmd_arg(cmd_arg), .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data(rsp_data), .scl_lo(scl_lo), .sda_lo(sda_lo), .sda_in(sda_line)
  );

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    nstart++; rcnt = 0; fcnt = 0; bits = '0; rdf = 0;
  end
  always @(posedge scl_line) begin
    bits = {bits[30:0], sda_line};
    rcnt++;
    if (rcnt == 8) rdf = sda_line;
  end
  always @(negedge scl_line) fcnt++;

  always @(negedge clk) begin
    cyc++;
    if (rsp_valid) rsp_cnt++;
    if (!busy) have_last = 0;
    else if ({scl_lo, sda_lo} != prev_lines) begin
      if (have_last && (cyc - last_chg) < mingap) mingap = cyc - last_chg;
      have_last = 1;
      last_chg  = cyc;
    end
    prev_lines = {scl_lo, sda_lo};
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [2:0] pin, logic arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pin = pin; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    r_lat = 0;
    while (!rsp_valid && r_lat < 5000) begin
      @(negedge clk);
      r_lat++;
    end
    r_err  = rsp_err;
    r_data = rsp_data;
  endtask

  task automatic do_cmd(logic [1:0] op, logic [2:0] pin, logic arg);
    send(op, pin, arg);
    wait_rsp();
  endtask

  task automatic write_frame(string tag, logic [1:0] op, logic [2:0] pin, logic arg, int exp_byte);
    int n0 = nstart;
    mingap = 1000000;
    do_cmd(op, pin, arg);
    repeat (2) @(negedge clk);
    chk({tag, " one frame"}, nstart - n0, 1);
    chk({tag, " R2 rising edges"}, rcnt, 19);
    chk({tag, " R2 address"}, bits[18:11], 8'hAC);
    chk({tag, " R3 ack slot left high"}, bits[10], 1);
    chk({tag, " R2 data byte"}, bits[9:2], exp_byte);
    chk({tag, " R12 step spacing"}, mingap, STEP);
    chk({tag, " R10 no error"}, r_err, 0);
  endtask

  task automatic no_bus(string tag, logic [1:0] op, logic [2:0] pin, logic arg, int exp_err);
    int n0 = nstart;
    do_cmd(op, pin, arg);
    repeat (STEP * 3) @(negedge clk);
    chk({tag, " no frame"}, nstart - n0, 0);
    chk({tag, " immediate response"}, r_lat, 0);
    chk({tag, " error flag"}, r_err, exp_err);
    chk({tag, " busy low"}, busy, 0);
  endtask

  task automatic t_reset();
    repeat (20) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 scl driver off", scl_lo, 0);
    chk("R1 sda driver off", sda_lo, 0);
    chk("R1 no frame after reset", nstart, 0);
    for (int p = 0; p < 5; p++) begin
      do_cmd(2'd2, 3'(p), 1'b0);
      chk("R1 R9 get output pin latch 0", r_data, 0);
      chk("R9 get latency", r_lat, 0);
    end
    chk("R9 get caused no frame", nstart, 0);
  endtask

  task automatic t_set_out();
    write_frame("R6 set pin2", 2'd0, 3'd2, 1'b1, 8'h04);
    do_cmd(2'd2, 3'd2, 1'b0);
    chk("R6 R9 readback pin2", r_data, 1);
  endtask

  task automatic t_toggle();
    write_frame("R11 toggle pin4", 2'd1, 3'd4, 1'b0, 8'h14);
    write_frame("R11 toggle pin2", 2'd1, 3'd2, 1'b0, 8'h10);
  endtask

  task automatic t_bad();
    no_bus("R5 pin5", 2'd0, 3'd5, 1'b1, 1);
    no_bus("R5 pin7", 2'd3, 3'd7, 1'b1, 1);
  endtask

  task automatic t_dir_saved();
    write_frame("R8 pin0 to input", 2'd3, 3'd0, 1'b1, 8'h11);
    no_bus("R7 set input pin0", 2'd0, 3'd0, 1'b1, 0);
    no_bus("R7 toggle input pin0", 2'd1, 3'd0, 1'b0, 0);
    write_frame("R7 R8 pin0 to output takes saved", 2'd3, 3'd0, 1'b0, 8'h10);
  endtask

  task automatic t_read();
    int n0;
    write_frame("R8 pin3 to input", 2'd3, 3'd3, 1'b1, 8'h18);
    tgt_byte = 8'h08;
    n0 = nstart;
    do_cmd(2'd2, 3'd3, 1'b0);
    repeat (2) @(negedge clk);
    chk("R4 one read frame", nstart - n0, 1);
    chk("R4 rising edges no master ack", rcnt, 18);
    chk("R4 address", bits[17:10], 8'hAD);
    chk("R4 byte on bus", bits[8:1], 8'h08);
    chk("R4 selected bit", r_data, 1);
    tgt_byte = 8'hF7;
    do_cmd(2'd2, 3'd3, 1'b0);
    chk("R4 selected bit low", r_data, 0);
    chk("R4 error flag", r_err, 0);
  endtask

  task automatic t_busy();
    int c0;
    send(2'd0, 3'd1, 1'b1);
    c0 = rsp_cnt;
    repeat (STEP * 10) @(negedge clk);
    chk("R10 busy mid frame", busy, 1);
    send(2'd0, 3'd1, 1'b0);
    wait_rsp();
    @(negedge clk);
    chk("R10 single response", rsp_cnt - c0, 1);
    chk("R10 frame data", bits[9:2], 8'h1A);
    do_cmd(2'd2, 3'd1, 1'b0);
    chk("R10 ignored command left pin1", r_data, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    nstart = 0; rcnt = 0; fcnt = 0; rdf = 0;
    t_reset();
    t_set_out();
    t_toggle();
    t_bad();
    t_dir_saved();
    t_read();
    t_busy();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule